// File: doc/BRIEF.md
# Parallel-Port Command Receiver

This block is the receive end of a byte-wide host link that carries a firmware image to a store. It takes each byte with a four-phase handshake. Ready is shown by a low busy line. The acknowledge line is pulsed low once the byte is latched. The block gathers groups of four bytes into 32-bit words, lowest byte first. The host first sends a framed command. A fixed four-byte signature leads it. Next come an opcode that chooses program or verify, a word that gives the starting byte offset, and a byte that gives the number of blocks.

After the offset and the count pass their checks, the block passes each data word of each block to a consumer over a valid/ready stream. While the consumer holds back, the host is stalled by keeping busy high. After the data words of a block comes a 32-bit wrapping sum of those words. A match pulses a block-good strobe. A mismatch, a bad offset or a bad count each raises its own error flag. The receiver then waits, busy high, until the clear input is pulsed. The address space is 2^SPACE_BITS bytes (16 MB by default). It is cut into blocks of 2^BLOCK_BITS bytes (256 KB by default).

Top module: `pport_cmd_rx`

## Requirements
- R1: In the ready phase busy_o is 0 and ack_n_o is 1. Once the synchronised strobe is seen low, the byte on pdata_i is latched and ack_n_o goes 0 with busy_o at 1. ack_n_o stays 0 until the strobe is seen high again. It then returns to 1 while busy_o stays 1 for at least that cycle.
- R2: While rst_n is low, busy_o=1, ack_n_o=1, out_valid_o=0, blk_ok_o=0, and all three error flags are 0.
- R3: A command opens with the bytes 0x4D, 0x50, 0x54, 0x21 in that order. A byte that does not match the expected signature byte is dropped, and the match restarts from the first signature byte.
- R4: The byte after the signature selects the mode. 0x50 means program (out_verify_o=0) and 0x56 means verify (out_verify_o=1). Any other byte is dropped, and the receiver goes back to waiting for the signature with no error raised.
- R5: Every multi-byte field is a 32-bit word sent as four bytes, least-significant byte first.
- R6: The offset word must be below 2^SPACE_BITS and have its low BLOCK_BITS bits at zero. Otherwise err_offset_o is raised and the count byte is not accepted.
- R7: The count byte must be nonzero, and offset + count*2^BLOCK_BITS must be no more than 2^SPACE_BITS. Otherwise err_count_o is raised.
- R8: Each block gives 2^(BLOCK_BITS-2) data words on out_data_o in arrival order. blk_addr_o carries the block's byte address, which is the offset for the first block and grows by 2^BLOCK_BITS for each later block. While out_valid_o is high and out_ready_i is low, out_data_o holds and busy_o stays 1.
- R9: After the data words of each block comes a checksum word. If it equals the 32-bit wrapping sum of those data words, blk_ok_o pulses for one cycle. If it does not, err_sum_o is raised.
- R10: Only one error flag is ever set at a time. It stays set, with busy_o at 1, until clear_i is sampled high. Then all flags clear and the receiver waits for the signature.
- R11: After the checksum of the last block passes, the receiver goes back to waiting for a new signature and signals ready again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_n_i | input | 1 | Host data strobe, active low, asynchronous |
| pdata_i | input | 8 | Host data byte |
| busy_o | output | 1 | High when not ready for a byte |
| ack_n_o | output | 1 | Byte acknowledge, active low |
| clear_i | input | 1 | Leaves the error state |
| out_valid_o | output | 1 | Data word available |
| out_ready_i | input | 1 | Consumer takes the word |
| out_data_o | output | 32 | Data word |
| out_verify_o | output | 1 | Current command is verify |
| blk_addr_o | output | SPACE_BITS | Byte address of the current block |
| blk_ok_o | output | 1 | One-cycle pulse when a block checksum matches |
| err_offset_o | output | 1 | Offset rejected |
| err_count_o | output | 1 | Count rejected |
| err_sum_o | output | 1 | Checksum mismatch |

## Verification
The bench goes after the edges of the bounds. One offset sits one block short of the top and has a count that fits exactly. Another offset is past the top, one is not aligned, one has a count of zero, and one has a count that overflows. A design that used < where it needed <=, or that dropped the alignment test, would accept or reject the wrong one. Data words are made large so that the checksum wraps, which catches a sum that saturates or is too narrow, and a corrupted checksum must raise only the sum flag. Stray bytes and a bad opcode before a good frame catch a parser that treats a mismatched byte as a fresh start or that drops into an error. A stalled consumer must hold the word and keep busy high, where a broken design would drop or overwrite data.

// File: rtl/pport_rx_pkg.sv
// Shared types and constants for the parallel-port command receiver.
// Assumes: byte values below are the frame's on-wire encodings.
package pport_rx_pkg;

    typedef enum logic [1:0] {
        LNK_HOLD,
        LNK_READY,
        LNK_ACK
    } lnk_state_t;

    typedef enum logic [2:0] {
        PS_SIG,
        PS_OPC,
        PS_OFS,
        PS_CNT,
        PS_DATA,
        PS_OUT,
        PS_SUM,
        PS_ERR
    } ps_state_t;

    localparam logic [7:0] OPC_PROG   = 8'h50;
    localparam logic [7:0] OPC_VERIFY = 8'h56;

    // Expected signature byte at a given position.
    function automatic logic [7:0] sig_byte(input logic [1:0] idx);
        case (idx)
            2'd0:    sig_byte = 8'h4D;
            2'd1:    sig_byte = 8'h50;
            2'd2:    sig_byte = 8'h54;
            default: sig_byte = 8'h21;
        endcase
    endfunction

endpackage

// File: rtl/pport_byte_link.sv
// Byte-level handshake with the host. It synchronises the strobe, shows
// ready with busy low, latches the byte on a low strobe, pulses ack low until
// the strobe is released, then holds busy until accept_i allows the next byte.
// Assumes: pdata_i is stable while the strobe is low.
module pport_byte_link
    import pport_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strobe_n_i,
    input  logic [7:0] pdata_i,
    input  logic       accept_i,
    output logic       busy_o,
    output logic       ack_n_o,
    output logic       byte_vld_o,
    output logic [7:0] byte_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   strobe_s;
    lnk_state_t             state_q;

    // Strobe synchroniser chain, idle-high.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], strobe_n_i};
    end

    assign strobe_s = sync_q[SYNC_STAGES-1];

    // Handshake phase sequencing and byte capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= LNK_HOLD;
            byte_q_clr();
        end else begin
            byte_vld_o <= 1'b0;
            case (state_q)
                LNK_HOLD:  if (accept_i) state_q <= LNK_READY;
                LNK_READY: if (!strobe_s) begin
                    byte_o     <= pdata_i;
                    byte_vld_o <= 1'b1;
                    state_q    <= LNK_ACK;
                end
                LNK_ACK:   if (strobe_s) state_q <= LNK_HOLD;
                default:   state_q <= LNK_HOLD;
            endcase
        end
    end

    task automatic byte_q_clr();
        byte_o     <= '0;
        byte_vld_o <= 1'b0;
    endtask

    assign busy_o  = (state_q != LNK_READY);
    assign ack_n_o = (state_q != LNK_ACK);

    // R1: a latched byte is being acknowledged in the following cycle.
    a_r1_ack_on_latch: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |-> !ack_n_o);
    // R1: acknowledge held until the synchronised strobe returns high.
    a_r1_ack_until_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n_o && !strobe_s) |=> !ack_n_o);

endmodule

// File: rtl/pport_word_pack.sv
// Gathers four bytes, least significant first, into a 32-bit word.
// Assumes: the parser enables it only at word-aligned field starts.
module pport_word_pack (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en_i,
    input  logic        clr_i,
    input  logic        byte_vld_i,
    input  logic [7:0]  byte_i,
    output logic        done_o,
    output logic [31:0] word_o
);

    logic [1:0] cnt_q;

    // Shift bytes in from the top so the first byte ends up lowest.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q  <= '0;
            word_o <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (en_i && byte_vld_i) begin
                word_o <= {byte_i, word_o[31:8]};
                cnt_q  <= cnt_q + 2'd1;
                done_o <= (cnt_q == 2'd3);
            end
        end
    end

endmodule

// File: rtl/pport_frame_parser.sv
// Command frame parser: signature, opcode, offset and count validation,
// data word streaming with valid/ready, per-block checksum and sticky errors.
// Assumes: byte and word events arrive no more than one per cycle.
module pport_frame_parser
    import pport_rx_pkg::*;
#(
    parameter int SPACE_BITS = 24,
    parameter int BLOCK_BITS = 18
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  byte_vld_i,
    input  logic [7:0]            byte_i,
    input  logic                  word_done_i,
    input  logic [31:0]           word_i,
    input  logic                  clear_i,
    input  logic                  out_ready_i,
    output logic                  pack_en_o,
    output logic                  pack_clr_o,
    output logic                  accept_o,
    output logic                  out_valid_o,
    output logic [31:0]           out_data_o,
    output logic                  out_verify_o,
    output logic [SPACE_BITS-1:0] blk_addr_o,
    output logic                  blk_ok_o,
    output logic                  err_offset_o,
    output logic                  err_count_o,
    output logic                  err_sum_o
);

    localparam int WIDX_W = BLOCK_BITS - 2;
    localparam int EW     = SPACE_BITS + 9;
    localparam logic [EW-1:0]         LIMIT    = EW'(1) << SPACE_BITS;
    localparam logic [SPACE_BITS-1:0] BLK_STEP = SPACE_BITS'(1) << BLOCK_BITS;

    ps_state_t         state_q;
    logic [1:0]        sig_idx_q;
    logic [7:0]        blocks_left_q;
    logic [WIDX_W-1:0] word_idx_q;
    logic [31:0]       sum_q;
    logic              offset_bad;
    logic              count_bad;
    logic [EW-1:0]     end_v;

    // Offset range and alignment test on the assembled word.
    always_comb begin
        offset_bad = (word_i[31:SPACE_BITS] != '0) || (word_i[BLOCK_BITS-1:0] != '0);
    end

    // Count test: nonzero and the run ends inside the space.
    always_comb begin
        end_v     = EW'(blk_addr_o) + (EW'(byte_i) << BLOCK_BITS);
        count_bad = (byte_i == 8'd0) || (end_v > LIMIT);
    end

    // Frame sequencing, validation, streaming and checksum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= PS_SIG;
            sig_idx_q     <= '0;
            blocks_left_q <= '0;
            word_idx_q    <= '0;
            sum_q         <= '0;
            out_data_o    <= '0;
            out_verify_o  <= 1'b0;
            blk_addr_o    <= '0;
            blk_ok_o      <= 1'b0;
            err_offset_o  <= 1'b0;
            err_count_o   <= 1'b0;
            err_sum_o     <= 1'b0;
        end else begin
            blk_ok_o <= 1'b0;
            case (state_q)
                PS_SIG: if (byte_vld_i) begin
                    if (byte_i == sig_byte(sig_idx_q)) begin
                        sig_idx_q <= sig_idx_q + 2'd1;
                        if (sig_idx_q == 2'd3) state_q <= PS_OPC;
                    end else begin
                        sig_idx_q <= '0;
                    end
                end
                PS_OPC: if (byte_vld_i) begin
                    if (byte_i == OPC_PROG) begin
                        out_verify_o <= 1'b0;
                        state_q      <= PS_OFS;
                    end else if (byte_i == OPC_VERIFY) begin
                        out_verify_o <= 1'b1;
                        state_q      <= PS_OFS;
                    end else begin
                        state_q <= PS_SIG;
                    end
                end
                PS_OFS: if (word_done_i) begin
                    blk_addr_o <= word_i[SPACE_BITS-1:0];
                    if (offset_bad) begin
                        err_offset_o <= 1'b1;
                        state_q      <= PS_ERR;
                    end else begin
                        state_q <= PS_CNT;
                    end
                end
                PS_CNT: if (byte_vld_i) begin
                    if (count_bad) begin
                        err_count_o <= 1'b1;
                        state_q     <= PS_ERR;
                    end else begin
                        blocks_left_q <= byte_i;
                        word_idx_q    <= '0;
                        sum_q         <= '0;
                        state_q       <= PS_DATA;
                    end
                end
                PS_DATA: if (word_done_i) begin
                    out_data_o <= word_i;
                    sum_q      <= sum_q + word_i;
                    state_q    <= PS_OUT;
                end
                PS_OUT: if (out_ready_i) begin
                    word_idx_q <= word_idx_q + WIDX_W'(1);
                    state_q    <= (word_idx_q == '1) ? PS_SUM : PS_DATA;
                end
                PS_SUM: if (word_done_i) begin
                    if (word_i != sum_q) begin
                        err_sum_o <= 1'b1;
                        state_q   <= PS_ERR;
                    end else begin
                        blk_ok_o      <= 1'b1;
                        sum_q         <= '0;
                        blk_addr_o    <= blk_addr_o + BLK_STEP;
                        blocks_left_q <= blocks_left_q - 8'd1;
                        state_q       <= (blocks_left_q == 8'd1) ? PS_SIG : PS_DATA;
                    end
                end
                PS_ERR: if (clear_i) begin
                    err_offset_o <= 1'b0;
                    err_count_o  <= 1'b0;
                    err_sum_o    <= 1'b0;
                    sig_idx_q    <= '0;
                    state_q      <= PS_SIG;
                end
                default: state_q <= PS_SIG;
            endcase
        end
    end

    assign out_valid_o = (state_q == PS_OUT);
    assign accept_o    = (state_q != PS_OUT) && (state_q != PS_ERR);
    assign pack_en_o   = (state_q == PS_OFS) || (state_q == PS_DATA) || (state_q == PS_SUM);
    assign pack_clr_o  = (state_q == PS_SIG) || (state_q == PS_ERR);

    // R8: a presented word is held until the consumer takes it.
    a_r8_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
    // R10: at most one error flag is set.
    a_r10_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_offset_o, err_count_o, err_sum_o}));
    // R10: an error flag stays set until clear.
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_offset_o || err_count_o || err_sum_o) && !clear_i)
            |=> (err_offset_o || err_count_o || err_sum_o));

endmodule

// File: rtl/pport_cmd_rx.sv
// Top of the parallel-port command receiver: handshake link, word packer
// and frame parser. The link is held busy while a byte or word is still
// moving through the pipe, so no byte can slip past a stall or an error.
// Assumes: SPACE_BITS <= 31, 3 <= BLOCK_BITS < SPACE_BITS.
module pport_cmd_rx #(
    parameter int SPACE_BITS  = 24,
    parameter int BLOCK_BITS  = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  strobe_n_i,
    input  logic [7:0]            pdata_i,
    output logic                  busy_o,
    output logic                  ack_n_o,
    input  logic                  clear_i,
    output logic                  out_valid_o,
    input  logic                  out_ready_i,
    output logic [31:0]           out_data_o,
    output logic                  out_verify_o,
    output logic [SPACE_BITS-1:0] blk_addr_o,
    output logic                  blk_ok_o,
    output logic                  err_offset_o,
    output logic                  err_count_o,
    output logic                  err_sum_o
);

    logic        byte_vld;
    logic [7:0]  byte_val;
    logic        word_done;
    logic [31:0] word_val;
    logic        pack_en;
    logic        pack_clr;
    logic        par_accept;
    logic        link_accept;

    // Only offer ready when the parser can take a byte and nothing is in flight.
    assign link_accept = par_accept && !byte_vld && !word_done;

    pport_byte_link #(.SYNC_STAGES(SYNC_STAGES)) link_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_n_i (strobe_n_i),
        .pdata_i    (pdata_i),
        .accept_i   (link_accept),
        .busy_o     (busy_o),
        .ack_n_o    (ack_n_o),
        .byte_vld_o (byte_vld),
        .byte_o     (byte_val)
    );

    pport_word_pack pack_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (pack_en),
        .clr_i      (pack_clr),
        .byte_vld_i (byte_vld),
        .byte_i     (byte_val),
        .done_o     (word_done),
        .word_o     (word_val)
    );

    pport_frame_parser #(
        .SPACE_BITS (SPACE_BITS),
        .BLOCK_BITS (BLOCK_BITS)
    ) parser_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_vld_i   (byte_vld),
        .byte_i       (byte_val),
        .word_done_i  (word_done),
        .word_i       (word_val),
        .clear_i      (clear_i),
        .out_ready_i  (out_ready_i),
        .pack_en_o    (pack_en),
        .pack_clr_o   (pack_clr),
        .accept_o     (par_accept),
        .out_valid_o  (out_valid_o),
        .out_data_o   (out_data_o),
        .out_verify_o (out_verify_o),
        .blk_addr_o   (blk_addr_o),
        .blk_ok_o     (blk_ok_o),
        .err_offset_o (err_offset_o),
        .err_count_o  (err_count_o),
        .err_sum_o    (err_sum_o)
    );

    // R8: while a word waits for the consumer the host is held off.
    a_r8_stall_busy: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> busy_o);
    // R10: in an error the host is held off.
    a_r10_err_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (err_offset_o || err_count_o || err_sum_o) |-> busy_o);

endmodule

// File: tb/pport_cmd_rx_tb_top.sv
// Bench for pport_cmd_rx with a 256-byte space of 16-byte blocks (4 words/block).
module pport_cmd_rx_tb_top;

    localparam int SB = 8;
    localparam int BB = 4;
    localparam int WPB = 1 << (BB - 2);

    // {mode[51:44], offset[43:12], count[11:4], bad_sum[3], stall[2], expect[1:0]}
    // expect: 0 ok, 1 offset error, 2 count error, 3 checksum error
    localparam logic [51:0] VECS [8] = '{
        {8'h50, 32'h0000_0000, 8'd1, 1'b0, 1'b0, 2'd0},
        {8'h56, 32'h0000_0020, 8'd2, 1'b0, 1'b1, 2'd0},
        {8'h50, 32'h0000_0008, 8'd1, 1'b0, 1'b0, 2'd1},
        {8'h50, 32'h0000_0100, 8'd1, 1'b0, 1'b0, 2'd1},
        {8'h56, 32'h0000_00F0, 8'd1, 1'b0, 1'b0, 2'd0},
        {8'h50, 32'h0000_00F0, 8'd2, 1'b0, 1'b0, 2'd2},
        {8'h50, 32'h0000_0000, 8'd0, 1'b0, 1'b0, 2'd2},
        {8'h50, 32'h0000_0010, 8'd1, 1'b1, 1'b0, 2'd3}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strobe_n = 1'b1;
    logic [7:0]    pdata = 8'h00;
    logic          clear = 1'b0;
    logic          out_ready = 1'b1;
    logic          busy, ack_n, out_valid, out_verify, blk_ok;
    logic          e_off, e_cnt, e_sum;
    logic [31:0]   out_data;
    logic [SB-1:0] blk_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int exp_wr = 0;
    int rx_rd = 0;
    int ok_cnt = 0;
    logic [31:0]   exp_data [256];
    logic [SB-1:0] exp_addr [256];
    logic          exp_vfy  [256];

    always #4 clk = ~clk;

    pport_cmd_rx #(.SPACE_BITS(SB), .BLOCK_BITS(BB)) dut_i (
        .clk(clk), .rst_n(rst_n), .strobe_n_i(strobe_n), .pdata_i(pdata),
        .busy_o(busy), .ack_n_o(ack_n), .clear_i(clear),
        .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
        .out_verify_o(out_verify), .blk_addr_o(blk_addr), .blk_ok_o(blk_ok),
        .err_offset_o(e_off), .err_count_o(e_cnt), .err_sum_o(e_sum)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Consumer side: R5 and R8 data, order and address checks.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            chk(out_data == exp_data[rx_rd], "R8 data word", out_data, exp_data[rx_rd]);
            chk(blk_addr == exp_addr[rx_rd], "R8 block address", 32'(blk_addr), 32'(exp_addr[rx_rd]));
            chk(out_verify == exp_vfy[rx_rd], "R4 mode flag", 32'(out_verify), 32'(exp_vfy[rx_rd]));
            rx_rd++;
        end
        if (rst_n && blk_ok) ok_cnt++;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        while (busy) @(negedge clk);
        pdata = b;
        @(negedge clk);
        strobe_n = 1'b0;
        while (ack_n) @(negedge clk);
        strobe_n = 1'b1;
        while (!ack_n) @(negedge clk);
    endtask

    // R5: least-significant byte first.
    task automatic send_word(input logic [31:0] w);
        for (int k = 0; k < 4; k++) send_byte(w[8*k +: 8]);
    endtask

    task automatic send_sig();
        send_byte(8'h4D); send_byte(8'h50); send_byte(8'h54); send_byte(8'h21);
    endtask

    function automatic logic [31:0] gen(input int tag, input int b, input int i);
        gen = 32'hF123_4567 * (tag + 1) + 32'(b << 12) + 32'h0101_0101 * i;
    endfunction

    task automatic send_frame(input logic [7:0] mode, input logic [31:0] off,
                              input logic [7:0] cnt, input bit bad, input bit stall,
                              input logic [1:0] expk, input int tag);
        logic [31:0] sum;
        logic [31:0] w;
        send_sig();
        send_byte(mode);
        send_word(off);
        if (expk == 2'd1) return;
        send_byte(cnt);
        if (expk == 2'd2) return;
        for (int b = 0; b < int'(cnt); b++) begin
            sum = '0;
            for (int i = 0; i < WPB; i++) begin
                w = gen(tag, b, i);
                exp_data[exp_wr] = w;
                exp_addr[exp_wr] = SB'(off) + SB'(b << BB);
                exp_vfy[exp_wr]  = (mode == 8'h56);
                exp_wr++;
                sum = sum + w;
                if (stall && b == 0 && i == 0) begin
                    out_ready = 1'b0;
                    send_word(w);
                    cyc(40);
                    chk(busy == 1'b1, "R8 busy held while stalled", 32'(busy), 32'd1);
                    chk(out_valid == 1'b1, "R8 word held while stalled", 32'(out_valid), 32'd1);
                    chk(out_data == w, "R8 stalled data stable", out_data, w);
                    out_ready = 1'b1;
                end else begin
                    send_word(w);
                end
            end
            send_word(bad ? (sum ^ 32'h0000_0001) : sum);
            if (bad) return;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int ok0;
        cyc(3);
        // R2: reset state
        chk(busy == 1'b1 && ack_n == 1'b1, "R2 link idle in reset", {busy, ack_n}, 2'b11);
        chk(!out_valid && !blk_ok, "R2 stream idle in reset", {out_valid, blk_ok}, 0);
        chk({e_off, e_cnt, e_sum} == 3'b000, "R2 flags clear in reset", {e_off, e_cnt, e_sum}, 0);
        rst_n = 1'b1;
        cyc(5);
        chk(busy == 1'b0 && ack_n == 1'b1, "R1 ready after reset", {busy, ack_n}, 2'b01);

        // R1: manual handshake on a stray byte, checked phase by phase.
        pdata = 8'h58;
        cyc(1);
        strobe_n = 1'b0;
        while (ack_n) @(negedge clk);
        chk(busy == 1'b1, "R1 busy during ack", 32'(busy), 32'd1);
        cyc(6);
        chk(ack_n == 1'b0, "R1 ack held while strobe low", 32'(ack_n), 32'd0);
        strobe_n = 1'b1;
        while (!ack_n) @(negedge clk);
        chk(busy == 1'b1, "R1 busy kept on ack release", 32'(busy), 32'd1);

        // Table walk: R6 R7 R9 R10 R11 and stall on R8.
        for (int v = 0; v < 8; v++) begin
            logic [51:0] e;
            e = VECS[v];
            ok0 = ok_cnt;
            send_frame(e[51:44], e[43:12], e[11:4], e[3], e[2], e[1:0], v);
            cyc(10);
            chk(rx_rd == exp_wr, "R8 word count", 32'(rx_rd), 32'(exp_wr));
            case (e[1:0])
                2'd0: begin
                    chk({e_off, e_cnt, e_sum} == 3'b000, "R9 no error", {e_off, e_cnt, e_sum}, 0);
                    chk(ok_cnt - ok0 == int'(e[11:4]), "R9 block ok pulses", 32'(ok_cnt - ok0), 32'(e[11:4]));
                    chk(busy == 1'b0, "R11 ready for next command", 32'(busy), 0);
                end
                2'd1: chk({e_off, e_cnt, e_sum} == 3'b100, "R6 offset error", {e_off, e_cnt, e_sum}, 3'b100);
                2'd2: chk({e_off, e_cnt, e_sum} == 3'b010, "R7 count error", {e_off, e_cnt, e_sum}, 3'b010);
                default: begin
                    chk({e_off, e_cnt, e_sum} == 3'b001, "R9 checksum error", {e_off, e_cnt, e_sum}, 3'b001);
                    chk(ok_cnt == ok0, "R9 no ok on bad sum", 32'(ok_cnt - ok0), 0);
                end
            endcase
            if (e[1:0] != 2'd0) begin
                cyc(20);
                chk(busy == 1'b1, "R10 busy held in error", 32'(busy), 32'd1);
                chk(e_off || e_cnt || e_sum, "R10 flag sticky", {e_off, e_cnt, e_sum}, 1);
                clear = 1'b1;
                cyc(1);
                clear = 1'b0;
                cyc(5);
                chk({e_off, e_cnt, e_sum} == 3'b000, "R10 cleared", {e_off, e_cnt, e_sum}, 0);
                chk(busy == 1'b0, "R10 ready after clear", 32'(busy), 0);
            end
        end

        // R3: stray and broken-signature bytes are dropped.
        send_byte(8'h4D); send_byte(8'h51); send_byte(8'h21);
        ok0 = ok_cnt;
        send_frame(8'h50, 32'h40, 8'd1, 1'b0, 1'b0, 2'd0, 20);
        cyc(10);
        chk(rx_rd == exp_wr && ok_cnt == ok0 + 1, "R3 frame after junk", 32'(rx_rd), 32'(exp_wr));

        // R4: unknown opcode returns to signature wait, no error, no words.
        send_sig();
        send_byte(8'h5A);
        cyc(10);
        chk({e_off, e_cnt, e_sum} == 3'b000 && busy == 1'b0, "R4 bad opcode ignored",
            {e_off, e_cnt, e_sum, busy}, 0);
        chk(rx_rd == exp_wr, "R4 no words on bad opcode", 32'(rx_rd), 32'(exp_wr));
        ok0 = ok_cnt;
        send_frame(8'h56, 32'h00, 8'd3, 1'b0, 1'b0, 2'd0, 21);
        cyc(10);
        chk(rx_rd == exp_wr && ok_cnt == ok0 + 3, "R11 multi-block verify", 32'(ok_cnt - ok0), 32'd3);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule